// File: doc/BRIEF.md
# Palette Stream Loader

This block fills a 256-entry colour lookup table from a stream of 32-bit words. A DMA engine supplies the words during a palette load phase. Each word holds two 16-bit entries, with the lower halfword first. The colour of an entry sits in its low 12 bits: red in [11:8], green in [7:4] and blue in [3:0]. The top nibble of entry 0 is a header code that selects the pixel depth. Entry 0 also carries colour 0 in its low 12 bits. The header code fixes how many entries the load contains.

A load begins with a pulse on `load_start`. The value of `chain_frame` at that pulse decides what happens when the load ends: either the block hands over to the frame phase, or it simply stops. The word stream has one trailing word beyond the palette data. That word is accepted and thrown away. When the last entry has been written, the block pulses `pal_loaded`.

Between loads, the pixel pipeline presents an 8-bit index and gets the stored colour back one cycle later. Index bits above the active depth are cleared before the lookup.

Top module: `pal_stream_loader`

## Requirements
- R1: After reset, `busy`, `s_ready`, `pal_loaded` and `frame_go` are 0 and `depth_code` is 0.
- R2: A `load_start` pulse raises `busy` and `s_ready` from the next cycle. Bits [15:12] of the first accepted word become `depth_code` and stay unchanged until the next load's first word.
- R3: In every word used for palette data, bits [11:0] become the colour of entry 2k and bits [27:16] become the colour of entry 2k+1, where k is the word's position in the load counting from 0. The other bits do not affect any colour.
- R4: The number of entries depends on the header code: codes 0, 1 and 2 give 128 entries, code 3 gives 256, and codes 4 to 15 give 16. The block accepts exactly entries/2 + 1 words and then drops `s_ready`.
- R5: `pal_loaded` is high for exactly one cycle, namely the cycle after the word that carries the last entry is accepted.
- R6: The trailing word is accepted but leaves every palette entry unchanged.
- R7: `frame_go` pulses for one cycle, in the cycle after the trailing word is accepted, and only if `chain_frame` was 1 at the load's start pulse.
- R8: `lut_color` shows the colour of entry (`lut_idx` AND mask) one cycle after the index is presented. The mask is 0x01 for code 0, 0x03 for code 1, 0x0F for code 2, 0xFF for code 3 and 0x0F for codes 4 to 15.
- R9: A `load_start` pulse during a load restarts the load at entry 0, and the new first word replaces the header code. `s_ready` is 0 in the cycle where `load_start` is high.
- R10: A cycle with `s_valid` low makes no progress and does not move the completion pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_start | input | 1 | Begins a new palette load |
| chain_frame | input | 1 | Sampled at start: 1 hands over to the frame phase at the end |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted when high together with s_valid |
| s_data | input | 32 | Stream word, lower halfword = earlier entry |
| lut_idx | input | 8 | Pixel index for lookup |
| lut_color | output | 12 | Colour for the index presented one cycle earlier |
| depth_code | output | 4 | Header code from the last load |
| busy | output | 1 | A load is in progress |
| pal_loaded | output | 1 | One-cycle pulse after the last entry is written |
| frame_go | output | 1 | One-cycle handover pulse to the frame phase |

## Verification
The assertions check the following on every cycle. The stream stays quiet while idle. The header code holds outside a load. `pal_loaded` lasts one cycle and occurs only inside a load. `frame_go` coincides with the end of a load. A stalled cycle never produces a completion pulse. Only the bench's scenarios can show that the word count tracks each header code, that both halfwords land in the right entries, that the trailing word is harmless, and that the depth masking of the lookup is correct. The bench shows this with full table sweeps after loads with each header code, with stalls, and with a restart in the middle of a load.

// File: rtl/pal_stream_loader.sv
module pal_stream_loader #(
  parameter int IDX_W  = 8,
  parameter int COL_W  = 12,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_start,
  input  logic              chain_frame,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  input  logic [IDX_W-1:0]  lut_idx,
  output logic [COL_W-1:0]  lut_color,
  output logic [WORD_W/2-COL_W-1:0] depth_code,
  output logic              busy,
  output logic              pal_loaded,
  output logic              frame_go
);
  localparam int HALF_W  = WORD_W / 2;
  localparam int CODE_W  = HALF_W - COL_W;
  localparam int PAIRS   = (1 << IDX_W) / 2;
  localparam int PAIR_W  = IDX_W - 1;
  localparam int CNT_W   = IDX_W;
  localparam int SMALL_P = 8;

  logic [2*COL_W-1:0] mem [PAIRS];
  logic [CNT_W-1:0]   wcnt;
  logic               mode_q;

  function automatic logic [CNT_W-1:0] pairs_for(input logic [CODE_W-1:0] c);
    case (c)
      0, 1, 2: pairs_for = CNT_W'(PAIRS / 2);
      3:       pairs_for = CNT_W'(PAIRS);
      default: pairs_for = CNT_W'(SMALL_P);
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] mask_for(input logic [CODE_W-1:0] c);
    case (c)
      0:       mask_for = IDX_W'(1);
      1:       mask_for = IDX_W'(3);
      2:       mask_for = IDX_W'(15);
      3:       mask_for = '1;
      default: mask_for = IDX_W'(15);
    endcase
  endfunction

  wire                take     = s_valid & s_ready;
  wire [CODE_W-1:0]   code_now = (wcnt == '0) ? s_data[HALF_W-1:COL_W] : depth_code;
  wire [CNT_W-1:0]    npairs   = pairs_for(code_now);
  wire                last_ent = take && (wcnt == npairs - CNT_W'(1));
  wire                last_wrd = take && (wcnt == npairs);
  wire [IDX_W-1:0]    eff_idx  = lut_idx & mask_for(depth_code);
  wire [2*COL_W-1:0]  rd_pair  = mem[eff_idx[IDX_W-1:1]];

  assign s_ready = busy & ~load_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      wcnt       <= '0;
      mode_q     <= 1'b0;
      depth_code <= '0;
      pal_loaded <= 1'b0;
      frame_go   <= 1'b0;
    end else begin
      pal_loaded <= last_ent;
      frame_go   <= last_wrd & mode_q;
      if (load_start) begin
        busy   <= 1'b1;
        wcnt   <= '0;
        mode_q <= chain_frame;
      end else if (take) begin
        wcnt <= wcnt + CNT_W'(1);
        if (wcnt == '0) depth_code <= s_data[HALF_W-1:COL_W];
        if (last_wrd) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take && (wcnt < npairs))
      mem[wcnt[PAIR_W-1:0]] <= {s_data[HALF_W +: COL_W], s_data[0 +: COL_W]};
    lut_color <= eff_idx[0] ? rd_pair[COL_W +: COL_W] : rd_pair[0 +: COL_W];
  end
endmodule

// File: rtl/pal_stream_loader_chk.sv
module pal_stream_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       s_valid,
  input logic       s_ready,
  input logic       pal_loaded,
  input logic       frame_go,
  input logic [3:0] depth_code
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !s_ready);

  p_code_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(depth_code));

  p_loaded_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pal_loaded |=> !pal_loaded);

  p_loaded_in_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pal_loaded |-> busy);

  p_go_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go |-> (!busy && $past(busy)));

  p_stall_no_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !s_valid) |=> (!pal_loaded && !frame_go));
endmodule

bind pal_stream_loader pal_stream_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .s_valid(s_valid), .s_ready(s_ready),
  .pal_loaded(pal_loaded), .frame_go(frame_go), .depth_code(depth_code)
);

// File: tb/pal_stream_loader_bench.sv
module pal_stream_loader_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_start = 1'b0, chain_frame = 1'b0, s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_data = '0;
  logic [7:0]  lut_idx = '0;
  logic [11:0] lut_color;
  logic [3:0]  depth_code;
  logic        busy, pal_loaded, frame_go;

  int tests = 0, fails = 0;
  logic [11:0] exp_pal [256];

  always #(CLK_P/2) clk = ~clk;

  pal_stream_loader u_pal_stream_loader (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .chain_frame(chain_frame),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .lut_idx(lut_idx),
    .lut_color(lut_color), .depth_code(depth_code), .busy(busy),
    .pal_loaded(pal_loaded), .frame_go(frame_go)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int npairs_of(input int c);
    return (c <= 2) ? 64 : (c == 3) ? 128 : 8;
  endfunction

  function automatic int mask_of(input int c);
    return (c == 0) ? 1 : (c == 1) ? 3 : (c == 2) ? 15 : (c == 3) ? 255 : 15;
  endfunction

  function automatic logic [11:0] colr(input int e, input int s);
    return 12'((e * 37 + s * 101 + 5) & 12'hFFF);
  endfunction

  task automatic do_start(input bit mode);
    @(negedge clk);
    load_start = 1'b1; chain_frame = mode; s_valid = 1'b1; s_data = '0;
    #1 chk(s_ready == 1'b0, "R9", s_ready, 0);
    @(negedge clk);
    load_start = 1'b0; s_valid = 1'b0;
  endtask

  task automatic feed(input int code, input int seed, input int nsend,
                      input int gap, input bit mode, input bit full);
    int np = npairs_of(code);
    int nwords = full ? np + 1 : nsend;
    int k = 0, prev = -1, cyc = 0;
    while (k < nwords) begin
      chk(pal_loaded == (prev == np - 1), "R5", pal_loaded, prev == np - 1);
      chk(frame_go == (prev == np && mode), "R7", frame_go, prev == np && mode);
      prev = -1;
      if (gap != 0 && (cyc % gap) == gap - 1) begin
        s_valid = 1'b0; // R10 stall
      end else begin
        s_valid = 1'b1;
        if (k >= np) s_data = 32'hFFFF_FFFF;
        else s_data = {4'h5, colr(2*k+1, seed), (k == 0) ? 4'(code) : 4'hA, colr(2*k, seed)};
      end
      #1;
      if (s_valid) begin
        chk(s_ready == 1'b1, "R2", s_ready, 1);
        if (s_ready) begin
          if (k < np) begin
            exp_pal[2*k]   = colr(2*k, seed);
            exp_pal[2*k+1] = colr(2*k+1, seed);
          end
          prev = k;
          k++;
        end
      end
      @(negedge clk);
      cyc++;
    end
    if (full) begin
      chk(pal_loaded == 1'b0, "R5", pal_loaded, 0);
      chk(frame_go == mode, "R7", frame_go, mode);
      s_valid = 1'b1; s_data = 32'h1234_5678;
      #1 chk(s_ready == 1'b0, "R4", s_ready, 0);
      @(negedge clk);
      chk(!pal_loaded && !frame_go, "R7", {pal_loaded, frame_go}, 0);
      s_valid = 1'b0;
      chk(depth_code == 4'(code), "R2", depth_code, code);
    end else begin
      s_valid = 1'b0;
    end
  endtask

  task automatic sweep(input int code);
    int m = mask_of(code);
    for (int i = 0; i < 256; i++) begin
      lut_idx = 8'(i);
      @(negedge clk);
      chk(lut_color == exp_pal[i & m], (code == 3) ? "R3" : "R8", lut_color, exp_pal[i & m]);
    end
    lut_idx = 8'd0;
    @(negedge clk);
    chk(lut_color == exp_pal[0], "R6", lut_color, exp_pal[0]);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int codes [6] = '{3, 0, 1, 2, 4, 9};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!busy && !s_ready && !pal_loaded && !frame_go, "R1",
        {busy, s_ready, pal_loaded, frame_go}, 0);
    chk(depth_code == 4'd0, "R1", depth_code, 0);

    foreach (codes[j]) begin
      do_start(codes[j] % 2);
      feed(codes[j], j + 1, 0, (codes[j] == 2 || codes[j] == 9) ? 3 : 0, codes[j] % 2, 1'b1);
      sweep(codes[j]);
    end

    do_start(1'b1);
    feed(3, 20, 10, 0, 1'b1, 1'b0);
    do_start(1'b0); // R9 restart mid-load
    feed(1, 21, 0, 4, 1'b0, 1'b1);
    chk(depth_code == 4'd1, "R9", depth_code, 1);
    sweep(1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule